// File: doc/BRIEF.md
# Tuner Synthesizer Serial Control Receiver

This block is a write-only two-wire (I2C) slave that sits behind a fast system clock and turns the control stream sent to a tuner's frequency synthesizer into stable register outputs. Both bus lines are synchronized and glitch-filtered inside the block. START and STOP conditions and the SCL edges are then found in the filtered view. The block acknowledges its own address and every data byte that follows by pulling SDA low through an open-drain enable.

After the address, the top bit of each data byte selects its meaning. A byte with top bit 0 opens a divider pair. It is followed by a byte that completes the 10-bit main divider and the 5-bit swallow count. A byte with top bit 1 is a control byte. It is followed by a band byte whose low four bits drive the band-switch outputs. A pair updates its outputs only when both of its bytes have arrived. A transfer that stops part-way leaves every output as it was. Once a pair is complete, the next byte is classified again, so one transfer may carry both pairs in either order.

The two device-select bits come from pins, so up to four receivers can share one bus. A repeated START with a matching address restarts reception at once.

Top module: `tuner_ctl_i2c`

## Requirements
- R1: After reset, all register outputs are 0 and `sda_oe` is 0.
- R2: An address byte equal to binary 11000, then `dev_sel[1]`, `dev_sel[0]`, then a 0 write bit (MSB first) is acknowledged with SDA low during the ninth SCL high phase. Any other address, including one with the write bit set to 1, is not acknowledged, and the bytes after it change no output and are not acknowledged until the next START.
- R3: A divider pair is a first byte with bit 7 = 0, followed by a second byte. It sets `main_div` = {first[6:0], second[7:5]} and `swallow` = second[4:0].
- R4: A control pair is a first byte with bit 7 = 1, followed by a band byte. From the first byte, bit 6 sets `pump_hi`, bit 5 sets `gain_lo`, bit 4 sets `pump_off`, bits 2:1 set `ref_sel` and bit 0 sets `vt_off`; bit 3 is ignored. From the band byte, bits 3:0 set `band`.
- R5: Outputs change only when the second byte of a pair arrives. If a pair is cut off by a STOP or a START, the earlier values stay in force.
- R6: After a pair completes, the next byte in the same transfer is classified again by its bit 7, so both pairs may follow one address in either order.
- R7: A START followed by a matching address restarts reception even without a STOP before it, and it discards any half-received pair.
- R8: Every data byte after an acknowledged address is acknowledged.
- R9: An SCL pulse shorter than `FILT_LEN` system clocks is not taken as a clock edge.
- R10: SDA may change in the same system clock cycle that SCL falls (zero data hold) without a false START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | When 1, the pad pulls SDA low (acknowledge) |
| dev_sel | input | 2 | Pin-selected device address bits |
| main_div | output | 10 | Main divider ratio |
| swallow | output | 5 | Swallow counter ratio |
| pump_hi | output | 1 | High charge-pump current select |
| gain_lo | output | 1 | Reduced gain select |
| pump_off | output | 1 | Charge pump disable |
| ref_sel | output | 2 | Reference divider ratio select |
| vt_off | output | 1 | Tuning voltage output disable |
| band | output | 4 | Band-switch outputs |

## Verification
Random transfers mix matching, foreign and read addresses with zero to five data bytes. The first data byte has a random top bit. A transfer ends with a STOP or runs straight into a repeated START. A reference model applied to these transfers tells correct pair routing apart from stale values that an abort left behind. Directed cases pin down each pair alone, both pairs in both orders, and pairs cut off by a STOP and by a START. Further directed cases send traffic to a foreign address and to a read address, inject a short SCL spike mid-byte, and change SDA on the very cycle SCL falls. Each of these separates real bit edges from false ones. The acknowledge level is sampled on every byte, so a missing or extra acknowledge shows up on its own.

// File: rtl/tci_pkg.sv
package tci_pkg;
   localparam logic [4:0] DEV_ID  = 5'b11000;
   localparam int         MAIN_W  = 10;
   localparam int         SWAL_W  = 5;
   localparam int         BAND_W  = 4;
   localparam int         REF_W   = 2;

   typedef enum logic [2:0] {
      BUS_IDLE, BUS_ADDR, BUS_DATA, BUS_ACK, BUS_IGNORE
   } bus_st_t;

   typedef enum logic [1:0] {
      PH_FIRST, PH_FREQ, PH_BAND
   } pair_ph_t;
endpackage

// File: rtl/tci_line_filter.sv
module tci_line_filter #(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_LEN    = 4,
   parameter int LAG         = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic line_o
);
   localparam int CW = (FILT_LEN > 2) ? $clog2(FILT_LEN) : 1;
   localparam logic [CW-1:0] CNT_MAX = CW'(FILT_LEN - 1);

   logic [SYNC_STAGES-1:0] sync_q;
   logic [CW-1:0]          cnt_q;
   logic                   filt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '1;
         cnt_q  <= '0;
         filt_q <= 1'b1;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
         if (sync_q[SYNC_STAGES-1] != filt_q) begin
            if (cnt_q == CNT_MAX) begin
               filt_q <= sync_q[SYNC_STAGES-1];
               cnt_q  <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end else begin
            cnt_q <= '0;
         end
      end
   end

   generate
      if (LAG == 0) begin : g_nolag
         assign line_o = filt_q;
      end else begin : g_lag
         logic [LAG-1:0] lag_q;
         if (LAG == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) lag_q <= '1;
               else        lag_q <= filt_q;
            end
         end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) lag_q <= '1;
               else        lag_q <= {lag_q[LAG-2:0], filt_q};
            end
         end
         assign line_o = lag_q[LAG-1];
      end
   endgenerate
endmodule

// File: rtl/tci_bus_fsm.sv
module tci_bus_fsm
   import tci_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_f,
   input  logic       sda_f,
   input  logic [1:0] dev_sel,
   output logic       sda_oe,
   output logic       xfer_go,
   output logic       byte_vld,
   output logic [7:0] byte_q,
   output bus_st_t    st_o
);
   bus_st_t    st_q;
   logic [3:0] cnt_q;
   logic [7:0] shreg_q;
   logic       scl_d, sda_d;
   logic       scl_rise, scl_fall, start_c, stop_c;

   assign scl_rise = scl_f & ~scl_d;
   assign scl_fall = ~scl_f & scl_d;
   assign start_c  = scl_f & scl_d & sda_d & ~sda_f;
   assign stop_c   = scl_f & scl_d & ~sda_d & sda_f;
   assign byte_q   = shreg_q;
   assign st_o     = st_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= BUS_IDLE;
         cnt_q    <= '0;
         shreg_q  <= '0;
         scl_d    <= 1'b1;
         sda_d    <= 1'b1;
         sda_oe   <= 1'b0;
         xfer_go  <= 1'b0;
         byte_vld <= 1'b0;
      end else begin
         scl_d    <= scl_f;
         sda_d    <= sda_f;
         xfer_go  <= 1'b0;
         byte_vld <= 1'b0;
         if (start_c) begin
            st_q   <= BUS_ADDR;
            cnt_q  <= '0;
            sda_oe <= 1'b0;
         end else if (stop_c) begin
            st_q   <= BUS_IDLE;
            sda_oe <= 1'b0;
         end else begin
            case (st_q)
               BUS_ADDR, BUS_DATA: begin
                  if (scl_rise && cnt_q < 4'd8) begin
                     shreg_q <= {shreg_q[6:0], sda_f};
                     cnt_q   <= cnt_q + 4'd1;
                  end else if (scl_fall && cnt_q == 4'd8) begin
                     cnt_q <= '0;
                     if (st_q == BUS_DATA) begin
                        sda_oe   <= 1'b1;
                        byte_vld <= 1'b1;
                        st_q     <= BUS_ACK;
                     end else if (shreg_q == {DEV_ID, dev_sel, 1'b0}) begin
                        sda_oe  <= 1'b1;
                        xfer_go <= 1'b1;
                        st_q    <= BUS_ACK;
                     end else begin
                        st_q <= BUS_IGNORE;
                     end
                  end
               end
               BUS_ACK: begin
                  if (scl_fall) begin
                     sda_oe <= 1'b0;
                     st_q   <= BUS_DATA;
                  end
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/tci_pair_regs.sv
module tci_pair_regs
   import tci_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              xfer_go,
   input  logic              byte_vld,
   input  logic [7:0]        byte_i,
   output logic [MAIN_W-1:0] main_div,
   output logic [SWAL_W-1:0] swallow,
   output logic              pump_hi,
   output logic              gain_lo,
   output logic              pump_off,
   output logic [REF_W-1:0]  ref_sel,
   output logic              vt_off,
   output logic [BAND_W-1:0] band
);
   pair_ph_t   ph_q;
   logic [6:0] hold_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q     <= PH_FIRST;
         hold_q   <= '0;
         main_div <= '0;
         swallow  <= '0;
         pump_hi  <= 1'b0;
         gain_lo  <= 1'b0;
         pump_off <= 1'b0;
         ref_sel  <= '0;
         vt_off   <= 1'b0;
         band     <= '0;
      end else if (xfer_go) begin
         ph_q <= PH_FIRST;
      end else if (byte_vld) begin
         case (ph_q)
            PH_FIRST: begin
               hold_q <= byte_i[6:0];
               ph_q   <= byte_i[7] ? PH_BAND : PH_FREQ;
            end
            PH_FREQ: begin
               main_div <= {hold_q, byte_i[7:5]};
               swallow  <= byte_i[4:0];
               ph_q     <= PH_FIRST;
            end
            default: begin
               pump_hi  <= hold_q[6];
               gain_lo  <= hold_q[5];
               pump_off <= hold_q[4];
               ref_sel  <= hold_q[2:1];
               vt_off   <= hold_q[0];
               band     <= byte_i[BAND_W-1:0];
               ph_q     <= PH_FIRST;
            end
         endcase
      end
   end
endmodule

// File: rtl/tuner_ctl_i2c.sv
module tuner_ctl_i2c
   import tci_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_LEN    = 4,
   parameter int SDA_LAG     = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe,
   input  logic [1:0]        dev_sel,
   output logic [MAIN_W-1:0] main_div,
   output logic [SWAL_W-1:0] swallow,
   output logic              pump_hi,
   output logic              gain_lo,
   output logic              pump_off,
   output logic [REF_W-1:0]  ref_sel,
   output logic              vt_off,
   output logic [BAND_W-1:0] band
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (FILT_LEN < 2) begin : g_bad_filt
         $error("FILT_LEN must be at least 2");
      end
      if (SDA_LAG < 1) begin : g_bad_lag
         $error("SDA_LAG must be at least 1 so SDA trails SCL");
      end
   endgenerate

   logic [1:0] line_raw, line_flt;
   logic       scl_f, sda_f;
   logic       xfer_go, byte_vld;
   logic [7:0] byte_q;
   bus_st_t    bus_st;

   assign line_raw = {sda_i, scl_i};
   assign scl_f    = line_flt[0];
   assign sda_f    = line_flt[1];

   generate
      for (genvar g = 0; g < 2; g++) begin : g_line
         tci_line_filter #(
            .SYNC_STAGES (SYNC_STAGES),
            .FILT_LEN    (FILT_LEN),
            .LAG         ((g == 1) ? SDA_LAG : 0)
         ) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (line_raw[g]),
            .line_o (line_flt[g])
         );
      end
   endgenerate

   tci_bus_fsm u_bus (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_f    (scl_f),
      .sda_f    (sda_f),
      .dev_sel  (dev_sel),
      .sda_oe   (sda_oe),
      .xfer_go  (xfer_go),
      .byte_vld (byte_vld),
      .byte_q   (byte_q),
      .st_o     (bus_st)
   );

   tci_pair_regs u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .xfer_go  (xfer_go),
      .byte_vld (byte_vld),
      .byte_i   (byte_q),
      .main_div (main_div),
      .swallow  (swallow),
      .pump_hi  (pump_hi),
      .gain_lo  (gain_lo),
      .pump_off (pump_off),
      .ref_sel  (ref_sel),
      .vt_off   (vt_off),
      .band     (band)
   );
endmodule

// File: rtl/tci_checker.sv
module tci_checker
   import tci_pkg::*;
(
   input logic              clk,
   input logic              rst_n,
   input logic              scl_f,
   input logic              sda_oe,
   input logic              byte_vld,
   input bus_st_t           bus_st,
   input logic [MAIN_W-1:0] main_div,
   input logic [SWAL_W-1:0] swallow,
   input logic [BAND_W-1:0] band
);
   // R5: divider outputs move only right after a byte hand-off
   p_main_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !byte_vld |=> ($stable(main_div) && $stable(swallow)));

   // R4: band outputs move only right after a byte hand-off
   p_band_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !byte_vld |=> $stable(band));

   // R8: acknowledge pull starts only while filtered SCL is low
   p_ack_scl_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> !scl_f);

   // R2: an ignored transfer never drives SDA
   p_ignore_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_st == BUS_IGNORE) |-> !sda_oe);

   // R3: one hand-off per received byte
   p_vld_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      byte_vld |=> !byte_vld);
endmodule

bind tuner_ctl_i2c tci_checker u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .scl_f    (scl_f),
   .sda_oe   (sda_oe),
   .byte_vld (byte_vld),
   .bus_st   (bus_st),
   .main_div (main_div),
   .swallow  (swallow),
   .band     (band)
);

// File: tb/tb_tuner_ctl_i2c.sv
module tb_tuner_ctl_i2c;
   localparam int Q = 20;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic [1:0] dev_sel = 2'b10;
   logic       sda_oe;
   logic [9:0] main_div;
   logic [4:0] swallow;
   logic       pump_hi, gain_lo, pump_off, vt_off;
   logic [1:0] ref_sel;
   logic [3:0] band;
   wire        sda_line = sda_m & ~sda_oe;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [9:0] e_main = '0;
   logic [4:0] e_sw = '0;
   logic [4:0] e_ctl = '0;
   logic [1:0] e_ref = '0;
   logic [3:0] e_band = '0;
   int         e_ph = 0;
   logic [6:0] e_hold = '0;
   logic [7:0] dbuf [0:5];
   bit         hold0 = 1'b0;
   int         glitch_at = -1;

   always #2.5 clk = ~clk;

   tuner_ctl_i2c dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
      .dev_sel(dev_sel), .main_div(main_div), .swallow(swallow), .pump_hi(pump_hi),
      .gain_lo(gain_lo), .pump_off(pump_off), .ref_sel(ref_sel), .vt_off(vt_off),
      .band(band)
   );

   function automatic logic [24:0] act_pack();
      return {main_div, swallow, pump_hi, gain_lo, pump_off, ref_sel, vt_off, band};
   endfunction

   function automatic logic [24:0] exp_pack();
      return {e_main, e_sw, e_ctl[4], e_ctl[3], e_ctl[2], e_ref, e_ctl[0], e_band};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wc(input int n);
      repeat (n) @(negedge clk);
   endtask

   // bench model of the pair rules (R3, R4, R5, R6)
   task automatic model_byte(input logic [7:0] b);
      case (e_ph)
         0: begin e_hold = b[6:0]; e_ph = b[7] ? 2 : 1; end
         1: begin e_main = {e_hold, b[7:5]}; e_sw = b[4:0]; e_ph = 0; end
         default: begin
            e_ctl  = {e_hold[6], e_hold[5], e_hold[4], 1'b0, e_hold[0]};
            e_ref  = e_hold[2:1];
            e_band = b[3:0];
            e_ph   = 0;
         end
      endcase
   endtask

   task automatic start_c();
      sda_m = 1'b1; wc(Q);
      scl_m = 1'b1; wc(Q);
      sda_m = 1'b0; wc(Q);
      scl_m = 1'b0; wc(Q);
   endtask

   task automatic stop_c();
      sda_m = 1'b0; wc(Q);
      scl_m = 1'b1; wc(Q);
      sda_m = 1'b1; wc(2*Q);
   endtask

   task automatic clk_bit(input logic b, input bit gl);
      if (hold0) sda_m = b;
      wc(Q);
      if (!hold0) sda_m = b;
      if (gl) begin scl_m = 1'b1; wc(2); scl_m = 1'b0; end
      wc(Q);
      scl_m = 1'b1; wc(2*Q);
      scl_m = 1'b0;
   endtask

   task automatic send_byte(input logic [7:0] b, input bit gl, output logic acked);
      for (int i = 7; i >= 0; i--) clk_bit(b[i], gl && i == 4);
      if (hold0) sda_m = 1'b1;
      wc(Q);
      sda_m = 1'b1;
      wc(Q);
      scl_m = 1'b1; wc(Q);
      acked = ~sda_line;
      wc(Q);
      scl_m = 1'b0;
   endtask

   task automatic do_xfer(input logic [7:0] a, input int n, input bit stop, input string tag);
      logic ak;
      bit   match;
      match = (a == {5'b11000, dev_sel, 1'b0});
      start_c();
      send_byte(a, 1'b0, ak);
      chk({tag, " R2 addr ack"}, {31'd0, ak}, {31'd0, match});
      if (match) e_ph = 0;
      for (int k = 0; k < n; k++) begin
         send_byte(dbuf[k], glitch_at == k, ak);
         chk({tag, " R8 data ack"}, {31'd0, ak}, {31'd0, match});
         if (match) model_byte(dbuf[k]);
      end
      if (stop) stop_c();
      wc(4);
      chk({tag, " outputs"}, {7'd0, act_pack()}, {7'd0, exp_pack()});
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog (all requirements): actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin : main
      int unsigned r;
      r = $urandom(32'd2024);
      wc(10);
      // R1: reset values
      chk("R1 reset outputs", {7'd0, act_pack()}, 32'd0);
      chk("R1 reset sda_oe", {31'd0, sda_oe}, 32'd0);
      rst_n = 1'b1;
      wc(20);

      dbuf[0] = 8'h35; dbuf[1] = 8'hAB;
      do_xfer(8'hC4, 2, 1'b1, "R3 divider pair");
      dbuf[0] = 8'hD5; dbuf[1] = 8'hF9;
      do_xfer(8'hC4, 2, 1'b1, "R4 control pair");
      dbuf[0] = 8'hA2; dbuf[1] = 8'h06; dbuf[2] = 8'h12; dbuf[3] = 8'h34;
      do_xfer(8'hC4, 4, 1'b1, "R6 control then divider");
      dbuf[0] = 8'h5E; dbuf[1] = 8'h71; dbuf[2] = 8'hCB; dbuf[3] = 8'h03;
      do_xfer(8'hC4, 4, 1'b1, "R6 divider then control");
      dbuf[0] = 8'h7F;
      do_xfer(8'hC4, 1, 1'b1, "R5 abort by stop");
      dbuf[0] = 8'hFF;
      do_xfer(8'hC4, 1, 1'b0, "R5 abort by start");
      dbuf[0] = 8'h01; dbuf[1] = 8'h23;
      do_xfer(8'hC4, 2, 1'b1, "R7 repeated start");
      dbuf[0] = 8'h55; dbuf[1] = 8'h66;
      do_xfer(8'hC0, 2, 1'b1, "R2 foreign address");
      dbuf[0] = 8'h12; dbuf[1] = 8'h34;
      do_xfer(8'hC5, 2, 1'b1, "R2 read address");
      glitch_at = 0;
      dbuf[0] = 8'h44; dbuf[1] = 8'h99;
      do_xfer(8'hC4, 2, 1'b1, "R9 scl glitch");
      glitch_at = -1;
      hold0 = 1'b1;
      dbuf[0] = 8'hB3; dbuf[1] = 8'h0A;
      do_xfer(8'hC4, 2, 1'b1, "R10 zero hold");
      hold0 = 1'b0;
      dev_sel = 2'b01; wc(10);
      dbuf[0] = 8'h2C; dbuf[1] = 8'hE7;
      do_xfer(8'hC2, 2, 1'b1, "R2 other select");

      for (int t = 0; t < 25; t++) begin
         logic [7:0] a;
         int  n;
         bit  st;
         a = {5'b11000, dev_sel, 1'b0};
         if ($urandom % 5 == 0) a = 8'($urandom);
         n = int'($urandom % 6);
         for (int k = 0; k < n; k++) dbuf[k] = 8'($urandom);
         st = ($urandom % 4) != 0;
         hold0 = ($urandom % 2) == 1;
         do_xfer(a, n, st, "R3 R4 R5 R7 random");
         if (st && ($urandom % 3 == 0)) begin
            dev_sel = 2'($urandom);
            wc(10);
         end
      end
      hold0 = 1'b0;
      stop_c();

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule